// File: doc/BRIEF.md
# TLB Invalidate and Synchronize Controller

This block keeps the valid bits of two small 2-way set-associative translation buffers, one serving instruction fetch and one serving data access. It handles the coherent invalidation of both buffers. A local invalidate request carries a 32-bit effective address. Bits 17:12 of that address select one of 64 sets, and every way of that set is cleared in both buffers on the same clock edge. The block then drives the invalidate onto a shared system bus so that other masters clear the same set. Invalidates that other masters place on the bus are snooped, and they clear the local buffers in the same way.

A synchronize request is a barrier. The block issues a global address-only bus transaction. That transaction completes only when it is granted without a retry. When the block snoops a synchronize transaction from another master while one of its own invalidations has not yet been broadcast, it answers with retry. A retried local synchronize is reissued until it completes, and a one-cycle done pulse is then returned to the requester.

A fill port sets single valid bits. A lookup port reads the valid bits of one set in both buffers. A set that is being invalidated in the current cycle reads as a miss. Invalidate and synchronize requests use a valid/ready handshake, and only one request is outstanding at a time.

Top module: `tlb_inval_sync_ctrl`

## Requirements
- R1: After reset every valid bit is clear, `bus_req` and `sync_done` are low, and both request ready outputs are high.
- R2: A fill (`fill_en`) sets the valid bit of way `fill_way` in set `fill_set` of the buffer selected by `fill_side` (0 = instruction, 1 = data). The lookup port shows the bit from the next cycle.
- R3: An accepted local invalidate clears every way of set `inv_req_ea[17:12]` in both buffers at the next edge. Other sets are left untouched. When a fill and a clear hit the same set in the same cycle, the clear wins.
- R4: A lookup of a set that a local or snooped invalidate clears in the same cycle reports all ways of both buffers invalid.
- R5: From the cycle after a local invalidate is accepted, `bus_req` is high with `bus_tt` = 5'b11000, `bus_m` = 1 and `bus_addr` equal to the request address. These are held until a cycle with `bus_gnt` high and `bus_retry` low. A grant with retry causes the transaction to be reissued.
- R6: A snooped transaction with `snp_valid` high and `snp_tt` = 5'b11000 clears every way of set `snp_addr[17:12]` in both buffers at the next edge.
- R7: An accepted synchronize request drives `bus_req` from the next cycle with `bus_tt` = 5'b01001, `bus_m` = 1 and `bus_addr` = 0. The transaction is reissued after each retry. `sync_done` pulses for exactly one cycle, in the cycle after the grant that had no retry.
- R8: `snp_retry` is high in the same cycle as a snooped `snp_tt` = 5'b01001 while a local invalidate has been accepted but not yet completed on the bus. It is low otherwise.
- R9: Both ready outputs are high only while no request is in progress. When both requests are valid together, the invalidate is taken first. A request presented while ready is low has no effect.
- R10: A snooped transaction whose `snp_tt` is neither code clears nothing and is not retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_req_valid | input | 1 | Local invalidate request |
| inv_req_ready | output | 1 | Controller can accept a request |
| inv_req_ea | input | 32 | Effective address of the invalidate |
| sync_req_valid | input | 1 | Local synchronize request |
| sync_req_ready | output | 1 | Controller can accept a synchronize |
| sync_done | output | 1 | One-cycle pulse when the synchronize has completed |
| fill_en | input | 1 | Set one valid bit |
| fill_side | input | 1 | 0 instruction buffer, 1 data buffer |
| fill_set | input | 6 | Set of the fill |
| fill_way | input | 1 | Way of the fill |
| lk_set | input | 6 | Set being looked up |
| lk_ivalid | output | 2 | Per-way valid, instruction buffer |
| lk_dvalid | output | 2 | Per-way valid, data buffer |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus grant; the transaction happens in this cycle |
| bus_retry | input | 1 | Retry response, sampled with the grant |
| bus_tt | output | 5 | Transfer type |
| bus_m | output | 1 | Global coherence attribute |
| bus_addr | output | 32 | Transaction address |
| snp_valid | input | 1 | Snooped transaction present |
| snp_tt | input | 5 | Snooped transfer type |
| snp_addr | input | 32 | Snooped address |
| snp_retry | output | 1 | Retry response to the snooped transaction |

## Verification
Lookup results and `snp_retry` respond in the same cycle as their inputs. Valid bit updates, the start of a bus request, the return to ready and `sync_done` all appear one edge after the event that causes them. The bench drives inputs on the falling edge and compares every output shortly afterwards with a behavioural model. That model advances once per rising edge, so every result is checked in exactly the cycle it is due. Directed sequences place retries, same-cycle lookups, snooped barriers and contending requests at known cycles. A long random phase then mixes all of them on a small range of sets.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;
   localparam logic [4:0] TT_INVAL = 5'b11000;
   localparam logic [4:0] TT_SYNC  = 5'b01001;

   typedef enum logic [1:0] {
      MST_IDLE = 2'd0,
      MST_INV  = 2'd1,
      MST_SYNC = 2'd2
   } mst_state_e;
endpackage

// File: rtl/tlb_valid_bank.sv
module tlb_valid_bank #(
   parameter int SETS  = 64,
   parameter int WAYS  = 2,
   parameter int SET_W = $clog2(SETS),
   parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             clr_a_en,
   input  logic [SET_W-1:0] clr_a_set,
   input  logic             clr_b_en,
   input  logic [SET_W-1:0] clr_b_set,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAYS-1:0]  rd_valid
);
   logic [WAYS-1:0] vbits [SETS];

   function automatic logic kill_of(input logic [SET_W-1:0] s,
                                    input logic ae, input logic [SET_W-1:0] as,
                                    input logic be, input logic [SET_W-1:0] bs);
      return (ae && as == s) || (be && bs == s);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vbits[s] <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) begin
            if (kill_of(SET_W'(s), clr_a_en, clr_a_set, clr_b_en, clr_b_set)) begin
               vbits[s] <= '0;
            end else if (fill_en && fill_set == SET_W'(s)) begin
               vbits[s][fill_way] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rd_valid = vbits[rd_set];
      if (kill_of(rd_set, clr_a_en, clr_a_set, clr_b_en, clr_b_set)) rd_valid = '0;
   end
endmodule

// File: rtl/tlb_bus_master.sv
module tlb_bus_master
   import tlb_inv_pkg::*;
#(
   parameter int EA_W  = 32,
   parameter int CNT_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inv_valid,
   input  logic [EA_W-1:0] inv_ea,
   input  logic            sync_valid,
   output logic            idle,
   output logic            inv_accept,
   output logic            sync_done,
   output logic            pend_nz,
   output logic            bus_req,
   input  logic            bus_gnt,
   input  logic            bus_retry,
   output logic [4:0]      bus_tt,
   output logic            bus_m,
   output logic [EA_W-1:0] bus_addr
);
   mst_state_e      st;
   logic [EA_W-1:0] held_ea;
   logic [CNT_W-1:0] pend_cnt;
   logic            xfer_ok;

   assign idle       = (st == MST_IDLE);
   assign inv_accept = idle && inv_valid;
   assign xfer_ok    = bus_gnt && !bus_retry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= MST_IDLE;
         held_ea   <= '0;
         sync_done <= 1'b0;
      end else begin
         sync_done <= 1'b0;
         unique case (st)
            MST_IDLE: begin
               if (inv_valid) begin
                  st      <= MST_INV;
                  held_ea <= inv_ea;
               end else if (sync_valid) begin
                  st <= MST_SYNC;
               end
            end
            MST_INV:  if (xfer_ok) st <= MST_IDLE;
            MST_SYNC: if (xfer_ok) begin
               st        <= MST_IDLE;
               sync_done <= 1'b1;
            end
            default:  st <= MST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_cnt <= '0;
      end else if (inv_accept) begin
         pend_cnt <= pend_cnt + 1'b1;
      end else if (st == MST_INV && xfer_ok) begin
         pend_cnt <= pend_cnt - 1'b1;
      end
   end

   assign pend_nz  = (pend_cnt != '0);
   assign bus_req  = !idle;
   assign bus_m    = !idle;
   assign bus_tt   = (st == MST_SYNC) ? TT_SYNC : TT_INVAL;
   assign bus_addr = (st == MST_INV) ? held_ea : '0;
endmodule

// File: rtl/tlb_snoop_decode.sv
module tlb_snoop_decode
   import tlb_inv_pkg::*;
#(
   parameter int EA_W    = 32,
   parameter int SET_LSB = 12,
   parameter int SET_W   = 6
) (
   input  logic             snp_valid,
   input  logic [4:0]       snp_tt,
   input  logic [EA_W-1:0]  snp_addr,
   input  logic             pend_nz,
   output logic             clr_en,
   output logic [SET_W-1:0] clr_set,
   output logic             snp_retry
);
   assign clr_en    = snp_valid && (snp_tt == TT_INVAL);
   assign clr_set   = snp_addr[SET_LSB +: SET_W];
   assign snp_retry = snp_valid && (snp_tt == TT_SYNC) && pend_nz;
endmodule

// File: rtl/tlb_inval_sync_ctrl.sv
module tlb_inval_sync_ctrl
   import tlb_inv_pkg::*;
#(
   parameter int EA_W    = 32,
   parameter int SETS    = 64,
   parameter int WAYS    = 2,
   parameter int SET_LSB = 12,
   parameter int CNT_W   = 2,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_req_valid,
   output logic             inv_req_ready,
   input  logic [EA_W-1:0]  inv_req_ea,
   input  logic             sync_req_valid,
   output logic             sync_req_ready,
   output logic             sync_done,
   input  logic             fill_en,
   input  logic             fill_side,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [SET_W-1:0] lk_set,
   output logic [WAYS-1:0]  lk_ivalid,
   output logic [WAYS-1:0]  lk_dvalid,
   output logic             bus_req,
   input  logic             bus_gnt,
   input  logic             bus_retry,
   output logic [4:0]       bus_tt,
   output logic             bus_m,
   output logic [EA_W-1:0]  bus_addr,
   input  logic             snp_valid,
   input  logic [4:0]       snp_tt,
   input  logic [EA_W-1:0]  snp_addr,
   output logic             snp_retry
);
   if (SET_LSB + SET_W > EA_W) begin : g_bad_index
      $error("set index field exceeds the address width");
   end
   if ((1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("WAYS must be at least one");
   end

   logic             idle, inv_accept, pend_nz;
   logic             snp_clr_en;
   logic [SET_W-1:0] snp_clr_set;
   logic [WAYS-1:0]  rd_valid [2];

   tlb_bus_master #(.EA_W(EA_W), .CNT_W(CNT_W)) u_master (
      .clk(clk), .rst_n(rst_n),
      .inv_valid(inv_req_valid), .inv_ea(inv_req_ea), .sync_valid(sync_req_valid),
      .idle(idle), .inv_accept(inv_accept), .sync_done(sync_done), .pend_nz(pend_nz),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_retry(bus_retry),
      .bus_tt(bus_tt), .bus_m(bus_m), .bus_addr(bus_addr)
   );

   tlb_snoop_decode #(.EA_W(EA_W), .SET_LSB(SET_LSB), .SET_W(SET_W)) u_snoop (
      .snp_valid(snp_valid), .snp_tt(snp_tt), .snp_addr(snp_addr), .pend_nz(pend_nz),
      .clr_en(snp_clr_en), .clr_set(snp_clr_set), .snp_retry(snp_retry)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      tlb_valid_bank #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .fill_en(fill_en && (fill_side == 1'(b))),
         .fill_set(fill_set), .fill_way(fill_way),
         .clr_a_en(inv_accept), .clr_a_set(inv_req_ea[SET_LSB +: SET_W]),
         .clr_b_en(snp_clr_en), .clr_b_set(snp_clr_set),
         .rd_set(lk_set), .rd_valid(rd_valid[b])
      );
   end

   assign lk_ivalid      = rd_valid[0];
   assign lk_dvalid      = rd_valid[1];
   assign inv_req_ready  = idle;
   assign sync_req_ready = idle;
endmodule

// File: rtl/tlb_inval_sync_chk.sv
module tlb_inval_sync_chk
   import tlb_inv_pkg::*;
#(
   parameter int EA_W    = 32,
   parameter int SET_LSB = 12,
   parameter int SET_W   = 6,
   parameter int WAYS    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inv_req_valid,
   input logic             inv_req_ready,
   input logic [EA_W-1:0]  inv_req_ea,
   input logic             sync_req_valid,
   input logic             sync_req_ready,
   input logic             sync_done,
   input logic [SET_W-1:0] lk_set,
   input logic [WAYS-1:0]  lk_ivalid,
   input logic [WAYS-1:0]  lk_dvalid,
   input logic             bus_req,
   input logic             bus_gnt,
   input logic             bus_retry,
   input logic [4:0]       bus_tt,
   input logic             bus_m,
   input logic [EA_W-1:0]  bus_addr,
   input logic             snp_valid,
   input logic [4:0]       snp_tt,
   input logic             snp_retry
);
   assert_inv_to_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req_valid && inv_req_ready |=> bus_req && bus_tt == TT_INVAL && bus_m);

   assert_hold_until_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !(bus_gnt && !bus_retry) |=> bus_req && $stable(bus_tt) && $stable(bus_addr));

   assert_sync_to_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req_valid && sync_req_ready && !inv_req_valid |=> bus_req && bus_tt == TT_SYNC && bus_m);

   assert_done_after_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_done |-> $past(bus_req && bus_gnt && !bus_retry && bus_tt == TT_SYNC));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_done |=> !sync_done);

   assert_retry_only_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_retry |-> snp_valid && snp_tt == TT_SYNC);

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !inv_req_ready && !sync_req_ready);

   assert_same_cycle_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req_valid && inv_req_ready && inv_req_ea[SET_LSB +: SET_W] == lk_set
      |-> lk_ivalid == '0 && lk_dvalid == '0);
endmodule

bind tlb_inval_sync_ctrl tlb_inval_sync_chk #(
   .EA_W(EA_W), .SET_LSB(SET_LSB), .SET_W(SET_W), .WAYS(WAYS)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .inv_req_valid(inv_req_valid), .inv_req_ready(inv_req_ready), .inv_req_ea(inv_req_ea),
   .sync_req_valid(sync_req_valid), .sync_req_ready(sync_req_ready), .sync_done(sync_done),
   .lk_set(lk_set), .lk_ivalid(lk_ivalid), .lk_dvalid(lk_dvalid),
   .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_retry(bus_retry),
   .bus_tt(bus_tt), .bus_m(bus_m), .bus_addr(bus_addr),
   .snp_valid(snp_valid), .snp_tt(snp_tt), .snp_retry(snp_retry)
);

// File: tb/tlb_inval_sync_ctrl_tb_top.sv
module tlb_inval_sync_ctrl_tb_top;
   localparam logic [4:0] C_INV  = 5'b11000;
   localparam logic [4:0] C_SYNC = 5'b01001;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        inv_req_valid, inv_req_ready, sync_req_valid, sync_req_ready, sync_done;
   logic [31:0] inv_req_ea;
   logic        fill_en, fill_side;
   logic [5:0]  fill_set, lk_set;
   logic [0:0]  fill_way;
   logic [1:0]  lk_ivalid, lk_dvalid;
   logic        bus_req, bus_gnt, bus_retry, bus_m;
   logic [4:0]  bus_tt;
   logic [31:0] bus_addr;
   logic        snp_valid, snp_retry;
   logic [4:0]  snp_tt;
   logic [31:0] snp_addr;

   tlb_inval_sync_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .inv_req_valid(inv_req_valid), .inv_req_ready(inv_req_ready), .inv_req_ea(inv_req_ea),
      .sync_req_valid(sync_req_valid), .sync_req_ready(sync_req_ready), .sync_done(sync_done),
      .fill_en(fill_en), .fill_side(fill_side), .fill_set(fill_set), .fill_way(fill_way),
      .lk_set(lk_set), .lk_ivalid(lk_ivalid), .lk_dvalid(lk_dvalid),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_retry(bus_retry),
      .bus_tt(bus_tt), .bus_m(bus_m), .bus_addr(bus_addr),
      .snp_valid(snp_valid), .snp_tt(snp_tt), .snp_addr(snp_addr), .snp_retry(snp_retry)
   );

   int    total = 0;
   int    bad = 0;
   bit    finished = 0;
   string ph = "reset";

   // behavioural reference: valid bits, request state (0 idle, 1 inv, 2 sync), pending count
   bit          mv [2][64][2];
   int          mst;
   logic [31:0] mea;
   int          mpend;
   bit          mdone;

   function automatic logic [5:0] set_of(input logic [31:0] a);
      return a[17:12];
   endfunction

   function automatic logic [31:0] ea_for(input int s);
      return {$urandom_range(16383, 0), 6'(s), 12'($urandom_range(4095, 0))};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, ph, act, exp, $time);
      end
   endtask

   function automatic bit killed(input logic [5:0] s);
      bit acc = (mst == 0) && inv_req_valid;
      return (acc && set_of(inv_req_ea) == s) ||
             (snp_valid && snp_tt == C_INV && set_of(snp_addr) == s);
   endfunction

   task automatic compare();
      logic [1:0] ei, ed;
      ei = {mv[0][lk_set][1], mv[0][lk_set][0]};
      ed = {mv[1][lk_set][1], mv[1][lk_set][0]};
      if (killed(lk_set)) begin ei = 2'b00; ed = 2'b00; end
      check("R9 inv ready", 64'(inv_req_ready), 64'(mst == 0));
      check("R9 sync ready", 64'(sync_req_ready), 64'(mst == 0));
      check("R2/R3/R4/R6 lookup instr", 64'(lk_ivalid), 64'(ei));
      check("R2/R3/R4/R6 lookup data", 64'(lk_dvalid), 64'(ed));
      check("R5/R7 bus_req", 64'(bus_req), 64'(mst != 0));
      if (mst != 0) begin
         check("R5/R7 bus_tt", 64'(bus_tt), 64'(mst == 1 ? C_INV : C_SYNC));
         check("R5/R7 bus_m", 64'(bus_m), 64'd1);
         check("R5/R7 bus_addr", 64'(bus_addr), 64'(mst == 1 ? mea : 32'd0));
      end
      check("R7 sync_done", 64'(sync_done), 64'(mdone));
      check("R8/R10 snp_retry", 64'(snp_retry),
            64'(snp_valid && snp_tt == C_SYNC && mpend != 0));
   endtask

   task automatic model_update();
      bit ok = bus_gnt && !bus_retry;
      bit kill [64];
      for (int s = 0; s < 64; s++) kill[s] = killed(6'(s));
      if (fill_en && !kill[fill_set]) mv[fill_side][fill_set][fill_way] = 1'b1;
      for (int s = 0; s < 64; s++)
         if (kill[s]) begin
            mv[0][s][0] = 0; mv[0][s][1] = 0; mv[1][s][0] = 0; mv[1][s][1] = 0;
         end
      mdone = (mst == 2) && ok;
      if (mst == 0) begin
         if (inv_req_valid) begin mst = 1; mea = inv_req_ea; mpend++; end
         else if (sync_req_valid) mst = 2;
      end else if (ok) begin
         if (mst == 1) mpend--;
         mst = 0;
      end
   endtask

   task automatic step();
      #1;
      if (!finished) compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic quiet();
      inv_req_valid = 0; inv_req_ea = '0; sync_req_valid = 0;
      fill_en = 0; fill_side = 0; fill_set = '0; fill_way = '0;
      bus_gnt = 0; bus_retry = 0; snp_valid = 0; snp_tt = '0; snp_addr = '0;
   endtask

   task automatic fill_all(input int s);
      for (int k = 0; k < 4; k++) begin
         fill_en = 1; fill_side = k[1]; fill_way = k[0]; fill_set = 6'(s);
         step();
      end
      fill_en = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog expired (%s) actual=hung expected=done", ph);
      finish_run();
   end

   initial begin
      quiet();
      lk_set = '0;
      rst_n = 0;
      for (int s = 0; s < 64; s++) begin
         mv[0][s][0] = 0; mv[0][s][1] = 0; mv[1][s][0] = 0; mv[1][s][1] = 0;
      end
      mst = 0; mea = '0; mpend = 0; mdone = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state seen at the ports
      #1;
      check("R1 inv ready", 64'(inv_req_ready), 64'd1);
      check("R1 bus_req", 64'(bus_req), 64'd0);
      check("R1 sync_done", 64'(sync_done), 64'd0);
      check("R1 lookup", 64'({lk_ivalid, lk_dvalid}), 64'd0);
      @(negedge clk);

      // R2: fills in sets 5, 6 and 7, read back
      ph = "fill";
      fill_all(5); fill_all(6); fill_all(7);
      lk_set = 6'd6; step();

      // R3, R4: local invalidate of set 5, looked up in the same cycle
      ph = "local inv";
      lk_set = 6'd5; inv_req_valid = 1; inv_req_ea = ea_for(5);
      step();
      inv_req_valid = 0;
      // R9: a synchronize while busy is ignored
      sync_req_valid = 1; lk_set = 6'd6; step();
      sync_req_valid = 0;
      // R8: snooped barrier while the broadcast is pending
      snp_valid = 1; snp_tt = C_SYNC; step();
      snp_valid = 0;
      // R5: grant with retry, then a clean grant
      bus_gnt = 1; bus_retry = 1; step();
      bus_retry = 0; step();
      bus_gnt = 0;
      snp_valid = 1; snp_tt = C_SYNC; step();   // R8: no retry once drained
      snp_valid = 0;

      // R6, R4: snooped invalidate of set 6 with a same-cycle lookup
      ph = "snoop inv";
      lk_set = 6'd6; snp_valid = 1; snp_tt = C_INV; snp_addr = ea_for(6); step();
      snp_valid = 0; step();
      // R10: unknown snoop type on set 7 clears nothing
      ph = "snoop other";
      lk_set = 6'd7; snp_valid = 1; snp_tt = 5'b00010; snp_addr = ea_for(7); step();
      snp_valid = 0; step();

      // R7: synchronize with two retries, then completion and done pulse
      ph = "sync";
      sync_req_valid = 1; step();
      sync_req_valid = 0;
      bus_gnt = 1; bus_retry = 1; step(); step();
      bus_retry = 0; step();
      bus_gnt = 0; step(); step();

      // R9: both requests at once, invalidate wins; R3 fill/clear collision on set 7
      ph = "contend";
      inv_req_valid = 1; inv_req_ea = ea_for(7); sync_req_valid = 1;
      fill_en = 1; fill_side = 1; fill_set = 6'd7; fill_way = 1'b0;
      step();
      quiet(); step();
      bus_gnt = 1; step();
      bus_gnt = 0; step();

      // random mix over sets 0..7
      ph = "random";
      for (int n = 0; n < 4000; n++) begin
         fill_en = ($urandom_range(9, 0) < 3); fill_side = 1'($urandom_range(1, 0));
         fill_way = 1'($urandom_range(1, 0)); fill_set = 6'($urandom_range(7, 0));
         lk_set = 6'($urandom_range(7, 0));
         inv_req_valid = ($urandom_range(9, 0) < 2); inv_req_ea = ea_for($urandom_range(7, 0));
         sync_req_valid = ($urandom_range(9, 0) < 2);
         bus_gnt = ($urandom_range(1, 0) == 1); bus_retry = ($urandom_range(9, 0) < 3);
         snp_valid = ($urandom_range(9, 0) < 3);
         case ($urandom_range(2, 0))
            0: snp_tt = C_INV;
            1: snp_tt = C_SYNC;
            default: snp_tt = 5'b00101;
         endcase
         snp_addr = ea_for($urandom_range(7, 0));
         step();
      end
      quiet();
      step();
      finish_run();
   end
endmodule